// File: doc/BRIEF.md
# Asynchronous DRAM Cycle Classifier

This block watches the control side of an asynchronous DRAM bus from the memory's point of view and names each cycle. The inputs are the row strobe, column strobe, output enable, the two byte write strobes and the multiplexed address. All are active low and sampled on a fast clock. The classifier works from the order in which the strobe edges arrive. It recognises ordinary reads, early writes, delayed writes, read-modify-write, the two refresh styles and long self-refresh, plus the page variants in which one row stays open across several column strobes.

Each strobe goes through a two-stage synchroniser before edge detection. The address goes through a matching two-stage delay. Edges seen on the same sample count as simultaneous. Every column strobe that falls inside an open row gives a one-clock column pulse carrying the column address. When the row strobe returns inactive, one summary pulse gives the cycle code, the latched row, the byte lanes written, the column count and a protocol-violation bit. It is meant for checking a controller in simulation and as the decode stage of a behavioural memory model.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, `cyc_valid`, `col_valid`, `cyc_type`, `cyc_ncols`, `cyc_lanes` and `cyc_viol` are all zero.
- R2: When the row strobe goes inactive, `cyc_valid` pulses for exactly one clock within four clocks. With it, `cyc_row` gives the address sampled on the sample where the row strobe became active.
- R3: An access with no write strobe active while the column strobe is low is a read, code 1.
- R4: A write strobe that is active on or before the sample where the column strobe becomes active makes an early write, code 2. The same sample counts as before.
- R5: A write strobe that becomes active after the column strobe makes a delayed write, code 3. If output enable was active in that access before any such write, the cycle is a read-modify-write, code 4.
- R6: A cycle in which the row strobe is active and the column strobe never falls is a row-only refresh, code 5, with `cyc_ncols` equal to 0 and `cyc_row` set to the row address.
- R7: If the column strobe is already active on the sample before the row strobe falls, the cycle is a column-before-row refresh, code 6. If the row strobe then stays low for more than `SELF_TICKS` samples, the cycle is self-refresh, code 7. Neither reports columns or lanes.
- R8: Each column strobe fall within an open row pulses `col_valid` once with the column on `col_addr`. `cyc_ncols` counts these pulses. Two or more make a page cycle, which adds 8 to the access code (9 to 12).
- R9: `cyc_lanes` bit 1 is the upper byte and bit 0 is the lower byte. Each bit is set when its own write strobe was active during an access, independent of the other.
- R10: If one byte lane is written early and the other delayed within the same access, `cyc_viol` is set.
- R11: If output enable is active while a delayed-write strobe is active, `cyc_viol` is set.
- R12: In a page cycle the reported base code is the highest code among its accesses: read < early < delayed < read-modify-write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| we_lo_n | input | 1 | Lower byte write strobe, active low |
| we_hi_n | input | 1 | Upper byte write strobe, active low |
| addr | input | AW | Multiplexed row/column address |
| col_valid | output | 1 | One-clock pulse per column strobe fall |
| col_addr | output | AW | Column latched for that pulse |
| cyc_valid | output | 1 | One-clock pulse at end of a cycle |
| cyc_type | output | 4 | Cycle code, see requirements |
| cyc_row | output | AW | Row latched at row strobe fall |
| cyc_lanes | output | 2 | Byte lanes written {upper, lower} |
| cyc_ncols | output | CNTW | Number of column strobes (saturating) |
| cyc_viol | output | 1 | Protocol violation seen in the cycle |

## Verification
The bench builds the block with `SELF_TICKS` set to 64 instead of the default of 20000, which corresponds to 100 µs at 200 MHz. This brings the self-refresh threshold within a short run, so that row strobe low times of exactly 64 and 65 samples can be compared on either side of the boundary. `AW` stays at 10 and `CNTW` at 4, so every page cycle in the bench stays far below the column count saturation.

// File: rtl/dram_cycle_decoder.sv
`timescale 1ns/1ps
module dram_cycle_decoder #(
  parameter int AW         = 10,
  parameter int SELF_TICKS = 20000,
  parameter int CNTW       = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            oe_n,
  input  logic            we_lo_n,
  input  logic            we_hi_n,
  input  logic [AW-1:0]   addr,
  output logic            col_valid,
  output logic [AW-1:0]   col_addr,
  output logic            cyc_valid,
  output logic [3:0]      cyc_type,
  output logic [AW-1:0]   cyc_row,
  output logic [1:0]      cyc_lanes,
  output logic [CNTW-1:0] cyc_ncols,
  output logic            cyc_viol
);
  localparam int SCW = $clog2(SELF_TICKS + 1);
  localparam logic [SCW-1:0]  SMAX = SCW'(SELF_TICKS);
  localparam logic [CNTW-1:0] NMAX = '1;
  localparam logic [2:0] K_READ = 3'd1, K_EARLY = 3'd2, K_DLY = 3'd3, K_RMW = 3'd4;
  localparam logic [3:0] T_RONLY = 4'd5, T_CBR = 4'd6, T_SELF = 4'd7;

  logic [4:0]    m1, m2, m3;
  logic [AW-1:0] a1, a2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= '0; m2 <= '0; m3 <= '0; a1 <= '0; a2 <= '0;
    end else begin
      m1 <= ~{oe_n, we_hi_n, we_lo_n, cas_n, ras_n};
      m2 <= m1;
      m3 <= m2;
      a1 <= addr;
      a2 <= a1;
    end
  end

  logic ras, cas, oe, ras_p, cas_p;
  logic [1:0] w, w_p;
  assign ras   = m2[0];
  assign cas   = m2[1];
  assign w     = m2[3:2];
  assign oe    = m2[4];
  assign ras_p = m3[0];
  assign cas_p = m3[1];
  assign w_p   = m3[3:2];

  logic ras_on, ras_off, cas_on, cas_off;
  assign ras_on  = ras & ~ras_p;
  assign ras_off = ~ras & ras_p;
  assign cas_on  = cas & ~cas_p;
  assign cas_off = ~cas & cas_p;

  logic            in_cyc, is_cbr, acc_open, acc_read, viol;
  logic [1:0]      acc_early, acc_dly, lanes;
  logic [2:0]      cyc_kind, acc_kind, kind_now;
  logic [CNTW-1:0] ncols;
  logic [SCW-1:0]  selfcnt;
  logic [AW-1:0]   row;
  logic            cbr_now;
  logic [1:0]      w_new;

  assign cbr_now = ras_on ? cas_p : is_cbr;
  assign w_new   = w & ~w_p & ~acc_early & ~acc_dly;

  always_comb begin
    if (|acc_early)    acc_kind = K_EARLY;
    else if (|acc_dly) acc_kind = acc_read ? K_RMW : K_DLY;
    else               acc_kind = K_READ;
    kind_now = (acc_open && acc_kind > cyc_kind) ? acc_kind : cyc_kind;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cyc <= 1'b0; is_cbr <= 1'b0; acc_open <= 1'b0; acc_read <= 1'b0; viol <= 1'b0;
      acc_early <= '0; acc_dly <= '0; lanes <= '0; cyc_kind <= '0; ncols <= '0;
      selfcnt <= '0; row <= '0;
      col_valid <= 1'b0; col_addr <= '0;
      cyc_valid <= 1'b0; cyc_type <= '0; cyc_row <= '0; cyc_lanes <= '0;
      cyc_ncols <= '0; cyc_viol <= 1'b0;
    end else begin
      cyc_valid <= 1'b0;
      col_valid <= 1'b0;

      if (ras_on) begin
        in_cyc <= 1'b1; is_cbr <= cas_p; row <= a2;
        cyc_kind <= '0; lanes <= '0; ncols <= '0; viol <= 1'b0;
        selfcnt <= '0; acc_open <= 1'b0;
      end else if (ras && is_cbr && selfcnt != SMAX) begin
        selfcnt <= selfcnt + 1'b1;
      end

      if (ras && !cbr_now) begin
        if (cas_on) begin
          acc_open  <= 1'b1;
          acc_early <= w;
          acc_dly   <= '0;
          acc_read  <= oe;
          cyc_kind  <= ras_on ? 3'd0 : kind_now;
          lanes     <= ras_on ? w : (lanes | w);
          ncols     <= ras_on ? CNTW'(1) : ((ncols == NMAX) ? ncols : ncols + 1'b1);
          col_valid <= 1'b1;
          col_addr  <= a2;
        end else if (acc_open) begin
          if (cas_off) begin
            cyc_kind <= kind_now;
            acc_open <= 1'b0;
          end else begin
            acc_dly <= acc_dly | w_new;
            lanes   <= lanes | w_new;
            if (oe && acc_dly == 2'b00 && w_new == 2'b00) acc_read <= 1'b1;
            if (((|w_new) && (|acc_early)) || (oe && (|(w & (acc_dly | w_new)))))
              viol <= 1'b1;
          end
        end
      end

      if (ras_off && in_cyc) begin
        in_cyc    <= 1'b0;
        acc_open  <= 1'b0;
        cyc_valid <= 1'b1;
        cyc_row   <= row;
        cyc_lanes <= lanes;
        cyc_ncols <= ncols;
        cyc_viol  <= viol;
        if (is_cbr)           cyc_type <= (selfcnt >= SMAX) ? T_SELF : T_CBR;
        else if (ncols == '0) cyc_type <= T_RONLY;
        else                  cyc_type <= {ncols > CNTW'(1), kind_now};
      end
    end
  end
endmodule

// File: rtl/dram_cycle_decoder_chk.sv
`timescale 1ns/1ps
module dram_cycle_decoder_chk #(
  parameter int AW   = 10,
  parameter int CNTW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            col_valid,
  input logic            cyc_valid,
  input logic [3:0]      cyc_type,
  input logic [1:0]      cyc_lanes,
  input logic [CNTW-1:0] cyc_ncols
);
  a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> !cyc_valid);

  a_r8_col_single: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |=> !col_valid);

  a_r8_col_not_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> !cyc_valid);

  a_r8_page_has_cols: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type[3]) |-> (cyc_ncols > CNTW'(1)));

  a_r6_rasonly_nocols: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == 4'd5) |-> (cyc_ncols == '0 && cyc_lanes == 2'b00));

  a_r7_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && (cyc_type == 4'd6 || cyc_type == 4'd7)) |-> (cyc_ncols == '0 && cyc_lanes == 2'b00));

  a_r3_read_nolanes: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type[2:0] == 3'd1) |-> (cyc_lanes == 2'b00));

  a_r9_write_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type[2:0] >= 3'd2 && cyc_type[2:0] <= 3'd4 && cyc_type != 4'd5)
      |-> (cyc_lanes != 2'b00));
endmodule

bind dram_cycle_decoder dram_cycle_decoder_chk #(.AW(AW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .col_valid(col_valid), .cyc_valid(cyc_valid),
  .cyc_type(cyc_type), .cyc_lanes(cyc_lanes), .cyc_ncols(cyc_ncols)
);

// File: tb/tb_dram_cycle_decoder.sv
`timescale 1ns/1ps
module tb_dram_cycle_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, oe_n = 1'b1, we_lo_n = 1'b1, we_hi_n = 1'b1;
  logic [9:0] addr = '0;
  logic col_valid, cyc_valid, cyc_viol;
  logic [9:0] col_addr, cyc_row;
  logic [3:0] cyc_type, cyc_ncols;
  logic [1:0] cyc_lanes;

  always #2.5 clk = ~clk;

  dram_cycle_decoder #(.AW(10), .SELF_TICKS(64), .CNTW(4)) dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
    .we_lo_n(we_lo_n), .we_hi_n(we_hi_n), .addr(addr),
    .col_valid(col_valid), .col_addr(col_addr), .cyc_valid(cyc_valid),
    .cyc_type(cyc_type), .cyc_row(cyc_row), .cyc_lanes(cyc_lanes),
    .cyc_ncols(cyc_ncols), .cyc_viol(cyc_viol));

  int vectors = 0, fails = 0;
  int ncol_got = 0, ecount = 0;
  logic got = 1'b0;
  logic [9:0] got_cols [16];
  logic [9:0] exp_cols [16];
  logic [3:0] g_type, g_ncols;
  logic [9:0] g_row;
  logic [1:0] g_lanes;
  logic g_viol;

  always @(negedge clk) begin
    if (col_valid) begin
      if (ncol_got < 16) got_cols[ncol_got] = col_addr;
      ncol_got = ncol_got + 1;
    end
    if (cyc_valid) begin
      got = 1'b1; g_type = cyc_type; g_row = cyc_row; g_lanes = cyc_lanes;
      g_ncols = cyc_ncols; g_viol = cyc_viol;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  task automatic ras_open(input logic [9:0] row);
    got = 1'b0; ncol_got = 0; ecount = 0;
    addr = row; step(1);
    ras_n = 1'b0; step(2);
  endtask

  // kind: 0 read, 1 early, 2 delayed, 3 read-modify-write
  task automatic cas_access(input logic [9:0] col, input int kind, input logic [1:0] ln, input bit sim);
    exp_cols[ecount] = col; ecount++;
    addr = col;
    if (kind == 1 && !sim) begin we_hi_n = ~ln[1]; we_lo_n = ~ln[0]; end
    step(1);
    cas_n = 1'b0;
    if (kind == 1 && sim) begin we_hi_n = ~ln[1]; we_lo_n = ~ln[0]; end
    case (kind)
      0: begin step(2); oe_n = 1'b0; step(2); oe_n = 1'b1; end
      1: step(2);
      2: begin step(2); we_hi_n = ~ln[1]; we_lo_n = ~ln[0]; step(2); end
      default: begin step(1); oe_n = 1'b0; step(2); oe_n = 1'b1; step(1);
                     we_hi_n = ~ln[1]; we_lo_n = ~ln[0]; step(2); end
    endcase
    we_hi_n = 1'b1; we_lo_n = 1'b1; cas_n = 1'b1;
    step(2);
  endtask

  task automatic close_check(input string tag, input int et, input int erow,
                             input int el, input int enc, input int ev);
    ras_n = 1'b1; cas_n = 1'b1;
    for (int i = 0; i < 8 && !got; i++) step(1);
    chk(tag, "valid", got, 1);
    chk(tag, "type", g_type, et);
    if (erow >= 0) chk(tag, "row", g_row, erow);
    chk(tag, "lanes", g_lanes, el);
    chk(tag, "ncols", g_ncols, enc);
    chk(tag, "viol", g_viol, ev);
    chk(tag, "col pulses", ncol_got, enc);
    for (int i = 0; i < enc && i < 16; i++) chk(tag, "col addr", got_cols[i], exp_cols[i]);
    step(3);
  endtask

  task automatic t_reset();
    chk("R1", "cyc_valid", cyc_valid, 0);
    chk("R1", "col_valid", col_valid, 0);
    chk("R1", "cyc_type", cyc_type, 0);
    chk("R1", "cyc_ncols", cyc_ncols, 0);
    chk("R1", "cyc_lanes", cyc_lanes, 0);
    chk("R1", "cyc_viol", cyc_viol, 0);
  endtask

  task automatic t_read();      // R2 R3
    ras_open(10'h2A5); cas_access(10'h013, 0, 2'b00, 0);
    close_check("R3 read", 1, 'h2A5, 0, 1, 0);
  endtask

  task automatic t_early();     // R4 R9
    ras_open(10'h101); cas_access(10'h0F0, 1, 2'b11, 0);
    close_check("R4 early", 2, 'h101, 3, 1, 0);
    ras_open(10'h102); cas_access(10'h0F1, 1, 2'b10, 0);
    close_check("R9 upper lane only", 2, 'h102, 2, 1, 0);
  endtask

  task automatic t_same_sample(); // R4
    ras_open(10'h0AA); cas_access(10'h055, 1, 2'b01, 1);
    close_check("R4 same sample", 2, 'h0AA, 1, 1, 0);
  endtask

  task automatic t_delayed();   // R5 R9
    ras_open(10'h321); cas_access(10'h007, 2, 2'b01, 0);
    close_check("R5 delayed", 3, 'h321, 1, 1, 0);
  endtask

  task automatic t_rmw();       // R5
    ras_open(10'h3FF); cas_access(10'h3FE, 3, 2'b11, 0);
    close_check("R5 rmw", 4, 'h3FF, 3, 1, 0);
  endtask

  task automatic t_ras_only();  // R6
    ras_open(10'h15A); step(5);
    close_check("R6 row-only", 5, 'h15A, 0, 0, 0);
  endtask

  task automatic t_cbr(input int low, input int et, input string tag); // R7
    got = 1'b0; ncol_got = 0; ecount = 0;
    cas_n = 1'b0; step(3);
    ras_n = 1'b0; step(low);
    close_check(tag, et, -1, 0, 0, 0);
  endtask

  task automatic t_page();      // R8 R12
    ras_open(10'h044);
    cas_access(10'h001, 0, 2'b00, 0); cas_access(10'h002, 0, 2'b00, 0); cas_access(10'h003, 0, 2'b00, 0);
    close_check("R8 page read", 9, 'h044, 0, 3, 0);
    ras_open(10'h045);
    cas_access(10'h010, 0, 2'b00, 0); cas_access(10'h011, 1, 2'b11, 0);
    close_check("R12 page read+early", 10, 'h045, 3, 2, 0);
    ras_open(10'h046);
    cas_access(10'h020, 2, 2'b10, 0); cas_access(10'h021, 2, 2'b01, 0);
    close_check("R8 page delayed", 11, 'h046, 3, 2, 0);
    ras_open(10'h047);
    cas_access(10'h030, 1, 2'b11, 0); cas_access(10'h031, 3, 2'b11, 0);
    close_check("R12 page rmw", 12, 'h047, 3, 2, 0);
  endtask

  task automatic t_stagger();   // R10
    ras_open(10'h200);
    exp_cols[0] = 10'h00C; ecount = 1;
    addr = 10'h00C; we_hi_n = 1'b0; step(1);
    cas_n = 1'b0; step(2);
    we_lo_n = 1'b0; step(2);
    we_hi_n = 1'b1; we_lo_n = 1'b1; cas_n = 1'b1; step(2);
    close_check("R10 stagger", 2, 'h200, 3, 1, 1);
  endtask

  task automatic t_oe_delayed(); // R11
    ras_open(10'h201);
    exp_cols[0] = 10'h00D; ecount = 1;
    addr = 10'h00D; step(1);
    cas_n = 1'b0; step(2);
    we_lo_n = 1'b0; step(1);
    oe_n = 1'b0; step(2);
    oe_n = 1'b1; we_lo_n = 1'b1; cas_n = 1'b1; step(2);
    close_check("R11 oe in delayed", 3, 'h201, 1, 1, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_read();
    t_early();
    t_same_sample();
    t_delayed();
    t_rmw();
    t_ras_only();
    t_cbr(10, 6, "R7 cbr");
    t_cbr(64, 6, "R7 cbr at limit");
    t_cbr(65, 7, "R7 self past limit");
    t_page();
    t_stagger();
    t_oe_delayed();
    summary();
    $finish;
  end
endmodule